// File: doc/BRIEF.md
# Circular ADC sample buffer writer

This block moves converted samples into a ring of 16-bit memory words with no processor involved. Every end-of-conversion strobe latches the sample on the ADC result port into a one-entry holding register. From there the sample is offered on a simple memory write port, at an address that steps by one halfword after each accepted write. The sample source never changes address. The destination wraps to the base address once the last entry of the programmed length is written, and it keeps cycling for as long as the block is enabled.

Software works in ping-pong fashion on the ring. A sticky half event sets when the lower half of the ring has been written, and a sticky full event sets when the upper half has been written. Software processes one half while the hardware fills the other.

A new strobe that arrives while a sample is still waiting for the memory raises a sticky overrun flag. In that case the waiting sample is kept and the new one is discarded. Each of the two ring events can drive the interrupt line through its own enable.

Top module: `adc_ring_writer`

## Requirements
- R1: After reset the write request is low, all three flags and the interrupt are low, and the write address equals the base address.
- R2: While enabled with nothing pending, an end-of-conversion strobe captures the sample. From the next cycle the write request is high and the write data equals that sample. Request, data and address hold until the cycle in which the memory ready is high.
- R3: The write address is the base address plus twice the ring index, so one halfword per entry. The index starts at 0 and advances by one on each accepted write. After the write at index length-1 it returns to 0, and this repeats indefinitely.
- R4: The half flag sets in the cycle after an accepted write at index length/2-1.
- R5: The full flag sets in the cycle after an accepted write at index length-1.
- R6: A strobe while enabled and while a sample is pending sets the overrun flag. This includes the cycle in which the pending sample is accepted. The pending sample stays unchanged and the new sample is dropped.
- R7: The half, full and overrun flags stay set until the matching clear input is 1 at a clock edge. If a flag is set and cleared in the same cycle, setting wins.
- R8: The interrupt is high whenever the half flag is set with its enable high, or the full flag is set with its enable high.
- R9: While the block is disabled, the ring index returns to 0, any pending sample is discarded (write request low) and strobes are ignored. Flags keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable; low resets index and pending sample |
| base_addr_i | input | ADDR_W | Byte address of ring entry 0 |
| len_i | input | IDX_W | Ring length in entries, even, at least 2 |
| eoc_i | input | 1 | End-of-conversion strobe |
| sample_i | input | DATA_W | ADC result |
| mem_req_o | output | 1 | Write request |
| mem_addr_o | output | ADDR_W | Write byte address |
| mem_data_o | output | DATA_W | Write data |
| mem_ready_i | input | 1 | Memory accepts the write this cycle |
| half_ie_i | input | 1 | Interrupt enable for half event |
| full_ie_i | input | 1 | Interrupt enable for full event |
| half_clr_i | input | 1 | Clear half flag |
| full_clr_i | input | 1 | Clear full flag |
| ovr_clr_i | input | 1 | Clear overrun flag |
| half_flag_o | output | 1 | Half event flag |
| full_flag_o | output | 1 | Full event flag |
| ovr_flag_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume an even length of at least 2 that changes only while the block is disabled, and a base address that holds steady. Under those conditions the half and full write addresses can be computed from the ports alone. The stimulus keeps to this: it picks a new length only in cycles where enable is low, fixes the base address, and draws lengths from a small set of even values. Strobe, ready, clear and enable inputs are otherwise random, so overruns, same-cycle set and clear, and accept-with-strobe collisions all occur freely.

// File: rtl/adc_ring_pkg.sv
package adc_ring_pkg;
  localparam int unsigned NUM_EV  = 3;
  localparam int unsigned EV_HALF = 0;
  localparam int unsigned EV_FULL = 1;
  localparam int unsigned EV_OVR  = 2;
endpackage

// File: rtl/adc_sample_hold.sv
module adc_sample_hold #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              eoc_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              take_i,
  output logic              pend_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ovr_o
);
  logic              pend_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (!enable_i) begin
      pend_q <= 1'b0;
    end else if (eoc_i && !pend_q) begin
      pend_q <= 1'b1;
      data_q <= sample_i;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end
  end

  // strobe while holding: keep old sample, drop new
  assign ovr_o  = enable_i & eoc_i & pend_q;
  assign pend_o = pend_q;
  assign data_o = data_q;
endmodule

// File: rtl/adc_ring_index.sv
module adc_ring_index #(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [IDX_W-1:0] len_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             half_o,
  output logic             full_o
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] half_len;
  logic             at_last;
  logic             at_mid;

  assign half_len = len_i >> 1;
  assign at_last  = (idx_q == len_i - ONE);
  assign at_mid   = (idx_q == half_len - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (!enable_i) idx_q <= '0;
    else if (step_i)    idx_q <= at_last ? '0 : idx_q + ONE;
  end

  assign idx_o  = idx_q;
  assign half_o = enable_i & step_i & at_mid;
  assign full_o = enable_i & step_i & at_last;
endmodule

// File: rtl/adc_event_flags.sv
module adc_event_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= (flag_q & ~clr_i[g]) | set_i[g];  // set wins
    end
    assign flags_o[g] = flag_q;
  end
endmodule

// File: rtl/adc_ring_writer.sv
module adc_ring_writer
  import adc_ring_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [IDX_W-1:0]  len_i,
  input  logic              eoc_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  input  logic              mem_ready_i,
  input  logic              half_ie_i,
  input  logic              full_ie_i,
  input  logic              half_clr_i,
  input  logic              full_clr_i,
  input  logic              ovr_clr_i,
  output logic              half_flag_o,
  output logic              full_flag_o,
  output logic              ovr_flag_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = ADDR_W - IDX_W - 1;

  logic              pend;
  logic              wr;
  logic              ovr_evt;
  logic              half_evt;
  logic              full_evt;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] byte_off;
  logic [NUM_EV-1:0] ev_set;
  logic [NUM_EV-1:0] ev_clr;
  logic [NUM_EV-1:0] flags;

  assign wr = pend & mem_ready_i;

  adc_sample_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .eoc_i   (eoc_i),
    .sample_i(sample_i),
    .take_i  (wr),
    .pend_o  (pend),
    .data_o  (mem_data_o),
    .ovr_o   (ovr_evt)
  );

  adc_ring_index #(.IDX_W(IDX_W)) u_index (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .len_i   (len_i),
    .step_i  (wr),
    .idx_o   (idx),
    .half_o  (half_evt),
    .full_o  (full_evt)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[EV_HALF] = half_evt;
    ev_set[EV_FULL] = full_evt;
    ev_set[EV_OVR]  = ovr_evt;
    ev_clr          = '0;
    ev_clr[EV_HALF] = half_clr_i;
    ev_clr[EV_FULL] = full_clr_i;
    ev_clr[EV_OVR]  = ovr_clr_i;
  end

  adc_event_flags #(.N(NUM_EV)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ev_set),
    .clr_i  (ev_clr),
    .flags_o(flags)
  );

  assign byte_off    = {{PAD_W{1'b0}}, idx, 1'b0};
  assign mem_addr_o  = base_addr_i + byte_off;
  assign mem_req_o   = pend;
  assign half_flag_o = flags[EV_HALF];
  assign full_flag_o = flags[EV_FULL];
  assign ovr_flag_o  = flags[EV_OVR];
  assign irq_o       = (flags[EV_HALF] & half_ie_i) | (flags[EV_FULL] & full_ie_i);
endmodule

// File: rtl/adc_ring_writer_chk.sv
module adc_ring_writer_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic [ADDR_W-1:0] base_addr_i,
  input logic [IDX_W-1:0]  len_i,
  input logic              eoc_i,
  input logic [DATA_W-1:0] sample_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_data_o,
  input logic              mem_ready_i,
  input logic              half_ie_i,
  input logic              full_ie_i,
  input logic              half_clr_i,
  input logic              full_clr_i,
  input logic              ovr_clr_i,
  input logic              half_flag_o,
  input logic              full_flag_o,
  input logic              ovr_flag_o,
  input logic              irq_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] mid_addr;
  logic [ADDR_W-1:0] last_addr;
  logic              accept;

  assign mid_addr  = base_addr_i + ADDR_W'({(len_i >> 1) - IDX_W'(1), 1'b0});
  assign last_addr = base_addr_i + ADDR_W'({len_i - IDX_W'(1), 1'b0});
  assign accept    = enable_i && mem_req_o && mem_ready_i;

  // R2
  write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_data_o) && $stable(mem_addr_o)));

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (mem_addr_o == $past(mem_addr_o) + STEP || mem_addr_o == base_addr_i));

  // R4
  half_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && mem_addr_o == mid_addr) |=> half_flag_o);

  // R5
  full_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && mem_addr_o == last_addr) |=> full_flag_o);

  // R6
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && mem_req_o && eoc_i) |=> ovr_flag_o);

  // R6
  overrun_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && mem_req_o && !mem_ready_i && eoc_i) |=> $stable(mem_data_o));

  // R7
  half_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_flag_o && !half_clr_i) |=> half_flag_o);

  // R7
  full_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_flag_o && !full_clr_i) |=> full_flag_o);

  // R9
  disable_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !mem_req_o);

  // R8
  always_comb begin
    if (rst_ni) begin
      irq_src_chk: assert (!irq_o || (half_flag_o && half_ie_i) || (full_flag_o && full_ie_i));
    end
  end
endmodule

bind adc_ring_writer adc_ring_writer_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/adc_ring_writer_test.sv
`timescale 1ns/1ps
module adc_ring_writer_test;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 10;
  localparam logic [ADDR_W-1:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              en = 0, eoc = 0, rdy = 0;
  logic              h_ie = 0, f_ie = 0, h_clr = 0, f_clr = 0, o_clr = 0;
  logic [IDX_W-1:0]  len = 4;
  logic [DATA_W-1:0] smp = '0;
  logic              req, half_f, full_f, ovr_f, irq;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;

  adc_ring_writer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .base_addr_i(BASE), .len_i(len),
    .eoc_i(eoc), .sample_i(smp), .mem_req_o(req), .mem_addr_o(addr),
    .mem_data_o(data), .mem_ready_i(rdy), .half_ie_i(h_ie), .full_ie_i(f_ie),
    .half_clr_i(h_clr), .full_clr_i(f_clr), .ovr_clr_i(o_clr),
    .half_flag_o(half_f), .full_flag_o(full_f), .ovr_flag_o(ovr_f), .irq_o(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  int                m_idx = 0;
  bit                m_pend = 0, m_half = 0, m_full = 0, m_ovr = 0;
  logic [DATA_W-1:0] m_data = '0;

  task automatic chk(bit ok, string r, string what, longint got, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, got, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] exp_addr();
    return BASE + ADDR_W'(2 * m_idx);
  endfunction

  task automatic model_step();
    bit wr, hs, fs, os;
    wr = en && m_pend && rdy;
    hs = 0; fs = 0; os = 0;
    if (en) begin
      os = eoc && m_pend;
      if (wr) begin
        hs = (m_idx == int'(len) / 2 - 1);
        fs = (m_idx == int'(len) - 1);
        m_idx = fs ? 0 : m_idx + 1;
      end
      if (eoc && !m_pend) begin
        m_pend = 1; m_data = smp;
      end else if (wr) m_pend = 0;
    end else begin
      m_idx = 0; m_pend = 0;
    end
    m_half = (m_half && !h_clr) || hs;
    m_full = (m_full && !f_clr) || fs;
    m_ovr  = (m_ovr && !o_clr) || os;
  endtask

  task automatic compare_all();
    chk(req == m_pend, "R2", "req", req, m_pend);
    if (m_pend) begin
      chk(data == m_data, "R2", "data", data, m_data);
      chk(addr == exp_addr(), "R3", "addr", addr, exp_addr());
    end
    chk(half_f == m_half, "R4", "half", half_f, m_half);
    chk(full_f == m_full, "R5", "full", full_f, m_full);
    chk(ovr_f == m_ovr, "R6", "ovr", ovr_f, m_ovr);
    chk(irq == ((m_half && h_ie) || (m_full && f_ie)), "R8", "irq", irq,
        (m_half && h_ie) || (m_full && f_ie));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic quiet();
    eoc = 0; h_clr = 0; f_clr = 0; o_clr = 0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req == 0, "R1", "req", req, 0);
    chk(half_f == 0 && full_f == 0 && ovr_f == 0, "R1", "flags",
        {half_f, full_f, ovr_f}, 0);
    chk(irq == 0, "R1", "irq", irq, 0);
    chk(addr == BASE, "R1", "addr", addr, BASE);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R4 R5: fill a 4-entry ring two and a half times
    en = 1; len = 4; rdy = 1;
    for (int k = 0; k < 10; k++) begin
      eoc = 1; smp = 16'h00A0 + 16'(k); tick();
      eoc = 0; tick();
    end
    chk(addr == BASE + 4, "R3", "wrap addr", addr, BASE + 4);
    chk(half_f == 1, "R4", "half after fill", half_f, 1);
    chk(full_f == 1, "R5", "full after fill", full_f, 1);

    // R7: clear half, full untouched
    h_clr = 1; tick(); quiet();
    chk(half_f == 0 && full_f == 1, "R7", "clear half", {half_f, full_f}, 2'b01);
    // R7: set and clear full in the same cycle -> set wins
    eoc = 1; smp = 16'h0B02; tick(); eoc = 0; tick();
    eoc = 1; smp = 16'h0B03; tick(); eoc = 0;
    f_clr = 1; tick(); quiet();
    chk(full_f == 1, "R7", "set wins", full_f, 1);
    f_clr = 1; tick(); quiet();
    chk(full_f == 0, "R7", "clear full", full_f, 0);

    // R6: overrun keeps first sample
    rdy = 0;
    eoc = 1; smp = 16'h1111; tick();
    eoc = 1; smp = 16'h2222; tick(); eoc = 0;
    chk(ovr_f == 1, "R6", "ovr set", ovr_f, 1);
    chk(data == 16'h1111, "R6", "kept sample", data, 16'h1111);
    rdy = 1; tick();
    o_clr = 1; tick(); quiet();
    chk(ovr_f == 0, "R7", "clear ovr", ovr_f, 0);

    // R8: enables gate the interrupt
    eoc = 1; smp = 16'h0C00; tick(); eoc = 0; tick();
    f_ie = 1; h_ie = 0; tick();
    chk(irq == full_f, "R8", "irq full", irq, full_f);
    f_ie = 0; tick();
    chk(irq == 0 || half_f && h_ie, "R8", "irq masked", irq, 0);

    // R9: disable drops pending sample, ignores strobes, rewinds index
    rdy = 0; eoc = 1; smp = 16'h3333; tick(); eoc = 0;
    en = 0; tick();
    chk(req == 0, "R9", "pending dropped", req, 0);
    eoc = 1; smp = 16'h4444; tick(); eoc = 0;
    chk(req == 0, "R9", "strobe ignored", req, 0);
    en = 1; eoc = 1; smp = 16'h5555; tick(); eoc = 0;
    chk(addr == BASE && data == 16'h5555, "R9", "index rewound", addr, BASE);
    rdy = 1; tick();

    // random phase
    for (int c = 0; c < 6000; c++) begin
      if (c % 500 == 499) begin
        en = 0; eoc = 0;
        case ($urandom_range(0, 5))
          0: len = 2; 1: len = 4; 2: len = 6;
          3: len = 8; 4: len = 12; default: len = 16;
        endcase
      end else begin
        en = 1;
        eoc = ($urandom_range(0, 99) < 35);
      end
      smp = 16'($urandom);
      rdy = ($urandom_range(0, 99) < 65);
      h_clr = ($urandom_range(0, 99) < 6);
      f_clr = ($urandom_range(0, 99) < 6);
      o_clr = ($urandom_range(0, 99) < 6);
      h_ie = $urandom_range(0, 1);
      f_ie = $urandom_range(0, 1);
      tick();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule